// File: doc/BRIEF.md
# Global Counter with Compare Interrupt

This block is a 64-bit up-counter that runs freely once started. It has one 64-bit comparator that raises an interrupt when the counter reaches a programmed value. A simple synchronous register bus reaches everything in the block. The bus is 32 bits wide, so the counter and the compare value are each written and read as a low word and a high word. The counter advances one step on each clock cycle in which the timer tick enable input is high and counting has been started.

The comparator works in two ways. In one-shot use, software loads a target of "now plus delta" and gets a single event. In auto-increment mode, every match adds a programmable 32-bit increment to the compare value. A single free-running counter then produces a periodic interrupt without further software action. A match always records a pending flag. The interrupt pin is that flag gated by an enable bit. The flag stays set until software writes a one to clear it.

Top module: `gtc_top`

## Requirements
- R1: After reset, every readable location returns zero and `irq` is low.
- R2: The counter increments by exactly one on each clock edge where control bit 8 (run) is set and `tick_en` is high, with carry from the low word into the high word. On any other edge it holds its value.
- R3: A write to offset 0x100 loads only the low 32 counter bits, and a write to 0x104 loads only the high 32 bits. On the edge of such a write the counter does not increment. Both words read back at the same offsets.
- R4: The compare value is written and read as a low word at 0x200 and a high word at 0x204. The 32-bit increment is written and read at 0x208.
- R5: When control bit 0 (compare enable) is set and the counter steps onto the compare value, status bit 0 at offset 0x244 reads 1 from that same clock edge. This happens whether or not the interrupt is enabled.
- R6: With control bit 1 (auto-increment) clear, a match leaves the compare value unchanged, so the event occurs only once.
- R7: With control bit 1 set, each match adds the increment to the 64-bit compare value on the same edge. Matches therefore repeat every increment-many counter steps.
- R8: `irq` is high exactly while status bit 0 and interrupt-enable bit 0 (offset 0x248) are both 1, and it stays high until the status is cleared. Only bit 0 of the enable register is stored.
- R9: Writing 1 to bit 0 of offset 0x244 clears the status. Writing 0 leaves it set. If a match and a clear fall on the same edge, the status stays set.
- R10: While control bit 0 is clear, the status does not become set, even when the counter passes the compare value.
- R11: The control register at 0x240 stores bits 0, 1 and 8 and reads all other bits as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick enable; qualifies counter steps |
| bus_wr | input | 1 | Register write strobe, taken on the rising edge |
| bus_addr | input | 12 | Register byte offset for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Compare interrupt, high while status and enable are both set |

## Verification
A register write takes effect on the rising edge at which `bus_wr` is sampled. Counter, compare and status results from that edge are readable half a cycle later. Read data is combinational from the address, so a read costs no cycle. For a counter started at value V, the bench counts falling edges after the start write: after N of them the counter holds V+N, and a target T is hit on the edge numbered T−V. Each check samples shortly after a falling edge, so every expected value is tied to a known count of rising edges. Same-edge cases are lined up by issuing the write one edge before the counter reaches the compare value. These cases are write-versus-increment, and set-versus-clear of the status.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

    // Register byte offsets (12-bit window)
    localparam logic [11:0] OFS_CNT_LO = 12'h100;
    localparam logic [11:0] OFS_CNT_HI = 12'h104;
    localparam logic [11:0] OFS_CMP_LO = 12'h200;
    localparam logic [11:0] OFS_CMP_HI = 12'h204;
    localparam logic [11:0] OFS_STEP   = 12'h208;
    localparam logic [11:0] OFS_CTL    = 12'h240;
    localparam logic [11:0] OFS_PEND   = 12'h244;
    localparam logic [11:0] OFS_IEN    = 12'h248;

    // Control register bit positions
    localparam int unsigned CTL_CMP_EN_BIT = 0;
    localparam int unsigned CTL_AUTO_BIT   = 1;
    localparam int unsigned CTL_RUN_BIT    = 8;

    typedef struct packed {
        logic run;
        logic auto_inc;
        logic cmp_en;
    } ctl_t;

endpackage

// File: rtl/gtc_counter.sv
module gtc_counter #(
    parameter int unsigned HALF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [HALF_W-1:0]     wdata,
    output logic [2*HALF_W-1:0]   cnt_o
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo || wr_hi) begin
            // a bus write replaces the step on this edge
            if (wr_lo) st_d.cnt[HALF_W-1:0]     = wdata;
            if (wr_hi) st_d.cnt[CNT_W-1:HALF_W] = wdata;
        end else if (step) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/gtc_compare.sv
module gtc_compare #(
    parameter int unsigned HALF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmp_en,
    input  logic                  auto_inc,
    input  logic                  step,
    input  logic [2*HALF_W-1:0]   cnt,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  wr_inc,
    input  logic [HALF_W-1:0]     wdata,
    output logic [2*HALF_W-1:0]   cmp_o,
    output logic [HALF_W-1:0]     inc_o,
    output logic                  hit_o
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic [HALF_W-1:0] inc;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        // event when the counter steps onto the target value
        hit = cmp_en && step && ((cnt + CNT_W'(1)) == st_q.cmp);
        if (wr_lo || wr_hi) begin
            if (wr_lo) st_d.cmp[HALF_W-1:0]     = wdata;
            if (wr_hi) st_d.cmp[CNT_W-1:HALF_W] = wdata;
        end else if (hit && auto_inc) begin
            st_d.cmp = st_q.cmp + CNT_W'(st_q.inc);
        end
        if (wr_inc) st_d.inc = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_o = st_q.cmp;
    assign inc_o = st_q.inc;
    assign hit_o = hit;
endmodule

// File: rtl/gtc_irq.sv
module gtc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic wr_pend,
    input  logic wr_ien,
    input  logic wbit,
    output logic pend_o,
    output logic ien_o,
    output logic irq_o
);
    typedef struct packed {
        logic pend;
        logic ien;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit)                  st_d.pend = 1'b1;  // set beats clear
        else if (wr_pend && wbit) st_d.pend = 1'b0;
        if (wr_ien)               st_d.ien  = wbit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign ien_o  = st_q.ien;
    assign irq_o  = st_q.pend & st_q.ien;
endmodule

// File: rtl/gtc_top.sv
module gtc_top
    import gtc_pkg::*;
#(
    parameter int unsigned HALF_W = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    ctl_t ctl_d, ctl_q;

    logic wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, wr_step, wr_ctl, wr_pend, wr_ien;
    logic step, hit, pend, ien;
    logic [CNT_W-1:0]  cnt_val, cmp_val;
    logic [HALF_W-1:0] inc_val;

    always_comb begin
        wr_cnt_lo = bus_wr && (bus_addr == ADDR_W'(OFS_CNT_LO));
        wr_cnt_hi = bus_wr && (bus_addr == ADDR_W'(OFS_CNT_HI));
        wr_cmp_lo = bus_wr && (bus_addr == ADDR_W'(OFS_CMP_LO));
        wr_cmp_hi = bus_wr && (bus_addr == ADDR_W'(OFS_CMP_HI));
        wr_step   = bus_wr && (bus_addr == ADDR_W'(OFS_STEP));
        wr_ctl    = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
        wr_pend   = bus_wr && (bus_addr == ADDR_W'(OFS_PEND));
        wr_ien    = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
    end

    assign step = ctl_q.run && tick_en && !wr_cnt_lo && !wr_cnt_hi;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl) begin
            ctl_d.run      = bus_wdata[CTL_RUN_BIT];
            ctl_d.auto_inc = bus_wdata[CTL_AUTO_BIT];
            ctl_d.cmp_en   = bus_wdata[CTL_CMP_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    gtc_counter #(.HALF_W(HALF_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .wr_lo (wr_cnt_lo),
        .wr_hi (wr_cnt_hi),
        .wdata (bus_wdata),
        .cnt_o (cnt_val)
    );

    gtc_compare #(.HALF_W(HALF_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_en   (ctl_q.cmp_en),
        .auto_inc (ctl_q.auto_inc),
        .step     (step),
        .cnt      (cnt_val),
        .wr_lo    (wr_cmp_lo),
        .wr_hi    (wr_cmp_hi),
        .wr_inc   (wr_step),
        .wdata    (bus_wdata),
        .cmp_o    (cmp_val),
        .inc_o    (inc_val),
        .hit_o    (hit)
    );

    gtc_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .wr_pend (wr_pend),
        .wr_ien  (wr_ien),
        .wbit    (bus_wdata[0]),
        .pend_o  (pend),
        .ien_o   (ien),
        .irq_o   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_CNT_LO): bus_rdata = cnt_val[HALF_W-1:0];
            ADDR_W'(OFS_CNT_HI): bus_rdata = cnt_val[CNT_W-1:HALF_W];
            ADDR_W'(OFS_CMP_LO): bus_rdata = cmp_val[HALF_W-1:0];
            ADDR_W'(OFS_CMP_HI): bus_rdata = cmp_val[CNT_W-1:HALF_W];
            ADDR_W'(OFS_STEP):   bus_rdata = inc_val;
            ADDR_W'(OFS_CTL): begin
                bus_rdata[CTL_RUN_BIT]    = ctl_q.run;
                bus_rdata[CTL_AUTO_BIT]   = ctl_q.auto_inc;
                bus_rdata[CTL_CMP_EN_BIT] = ctl_q.cmp_en;
            end
            ADDR_W'(OFS_PEND):   bus_rdata[0] = pend;
            ADDR_W'(OFS_IEN):    bus_rdata[0] = ien;
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gtc_checker.sv
module gtc_checker #(
    parameter int unsigned HALF_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                step,
    input logic                wr_cnt_lo,
    input logic                wr_cnt_hi,
    input logic [2*HALF_W-1:0] cnt,
    input logic                hit,
    input logic [2*HALF_W-1:0] cmp,
    input logic [HALF_W-1:0]   inc,
    input logic                auto_inc,
    input logic                cmp_en,
    input logic                wr_cmp_lo,
    input logic                wr_cmp_hi,
    input logic                pend,
    input logic                ien,
    input logic                irq
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cnt == $past(cnt) + CNT_W'(1));

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt));

    assert_hit_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend);

    assert_oneshot_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !auto_inc && !wr_cmp_lo && !wr_cmp_hi) |=> $stable(cmp));

    assert_auto_add_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && auto_inc && !wr_cmp_lo && !wr_cmp_hi) |=> cmp == $past(cmp) + CNT_W'($past(inc)));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien);

    assert_no_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !pend) |=> !pend);
endmodule

bind gtc_top gtc_checker #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .wr_cnt_lo (wr_cnt_lo),
    .wr_cnt_hi (wr_cnt_hi),
    .cnt       (cnt_val),
    .hit       (hit),
    .cmp       (cmp_val),
    .inc       (inc_val),
    .auto_inc  (ctl_q.auto_inc),
    .cmp_en    (ctl_q.cmp_en),
    .wr_cmp_lo (wr_cmp_lo),
    .wr_cmp_hi (wr_cmp_hi),
    .pend      (pend),
    .ien       (ien),
    .irq       (irq)
);

// File: tb/tb_gtc_top.sv
`timescale 1ns/1ps
module tb_gtc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gtc_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.4;
        v = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        logic [11:0] offs [8] = '{12'h100, 12'h104, 12'h200, 12'h204,
                                  12'h208, 12'h240, 12'h244, 12'h248};
        for (int i = 0; i < 8; i++) begin
            if (i % 4 == 0) @(negedge clk);
            rd(offs[i], v);
            chk("R1 reset value", v, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_count;
        logic [31:0] lo, hi;
        tick_en = 1'b1;
        wait_n(5);
        rd(12'h100, lo);
        chk("R2 no count while stopped", lo, 32'h0);
        wr(12'h100, 32'hFFFF_FFFE);
        wr(12'h104, 32'h0000_0001);
        rd(12'h100, lo); rd(12'h104, hi);
        chk("R3 low word load", lo, 32'hFFFF_FFFE);
        chk("R3 high word load", hi, 32'h0000_0001);
        wr(12'h240, 32'h0000_0100);
        wait_n(3);
        rd(12'h100, lo); rd(12'h104, hi);
        chk("R2 count with carry lo", lo, 32'h0000_0001);
        chk("R2 count with carry hi", hi, 32'h0000_0002);
        tick_en = 1'b0;
        wait_n(4);
        rd(12'h100, lo); rd(12'h104, hi);
        chk("R2 hold without tick lo", lo, 32'h0000_0001);
        chk("R2 hold without tick hi", hi, 32'h0000_0002);
        tick_en = 1'b1;
        wr(12'h104, 32'h0000_000A);
        rd(12'h100, lo); rd(12'h104, hi);
        chk("R3 write wins, low untouched", lo, 32'h0000_0001);
        chk("R3 high half loaded", hi, 32'h0000_000A);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        wr(12'h240, 32'h0);
        wr(12'h100, 32'h0);
        wr(12'h104, 32'h0);
        wr(12'h200, 32'd10);
        wr(12'h204, 32'h0);
        wr(12'h248, 32'h1);
        rd(12'h200, v); chk("R4 compare low readback", v, 32'd10);
        rd(12'h204, v); chk("R4 compare high readback", v, 32'h0);
        wr(12'h240, 32'h0000_0101);
        wait_n(9);
        rd(12'h244, v); chk("R5 no status before match", v, 32'h0);
        chk("R8 irq low before match", {31'b0, irq}, 32'h0);
        wait_n(1);
        rd(12'h244, v); chk("R5 status at match edge", v, 32'h1);
        chk("R8 irq with enable", {31'b0, irq}, 32'h1);
        rd(12'h200, v); chk("R6 compare kept in one-shot", v, 32'd10);
        wait_n(5);
        chk("R8 irq held until cleared", {31'b0, irq}, 32'h1);
        wr(12'h244, 32'h1);
        rd(12'h244, v); chk("R9 clear by writing one", v, 32'h0);
        chk("R8 irq drops on clear", {31'b0, irq}, 32'h0);
        wait_n(10);
        rd(12'h244, v); chk("R6 single event only", v, 32'h0);
    endtask

    task automatic t_autoinc;
        logic [31:0] v;
        wr(12'h240, 32'h0);
        wr(12'h100, 32'h0);
        wr(12'h104, 32'h0);
        wr(12'h200, 32'd5);
        wr(12'h204, 32'h0);
        wr(12'h208, 32'd7);
        wr(12'h248, 32'h0);
        rd(12'h208, v); chk("R4 increment readback", v, 32'd7);
        wr(12'h240, 32'h0000_0103);
        wait_n(5);
        rd(12'h244, v); chk("R5 status set with irq disabled", v, 32'h1);
        chk("R8 irq low when disabled", {31'b0, irq}, 32'h0);
        rd(12'h200, v); chk("R7 compare advanced by increment", v, 32'd12);
        wr(12'h244, 32'h0);
        rd(12'h244, v); chk("R9 writing zero keeps status", v, 32'h1);
        wr(12'h244, 32'h1);
        rd(12'h244, v); chk("R9 cleared", v, 32'h0);
        wait_n(5);
        rd(12'h244, v); chk("R7 second periodic match", v, 32'h1);
        rd(12'h200, v); chk("R7 compare advanced again", v, 32'd19);
        wr(12'h244, 32'h1);
        wr(12'h248, 32'hFFFF_FFFF);
        rd(12'h248, v); chk("R8 enable stores only bit 0", v, 32'h1);
        wait_n(5);
        chk("R8 irq on third match", {31'b0, irq}, 32'h1);
        rd(12'h200, v); chk("R7 compare third step", v, 32'd26);
        wait_n(6);
        wr(12'h244, 32'h1);
        rd(12'h244, v); chk("R9 set wins over same-edge clear", v, 32'h1);
        rd(12'h200, v); chk("R7 compare after fourth match", v, 32'd33);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        wr(12'h240, 32'h0000_0100);
        wr(12'h248, 32'h0);
        wr(12'h244, 32'h1);
        wait_n(10);
        rd(12'h100, v); chk("R2 counter passed target", v, 32'd39);
        rd(12'h244, v); chk("R10 no status while compare disabled", v, 32'h0);
        chk("R10 irq low when stopped", {31'b0, irq}, 32'h0);
        rd(12'h200, v); chk("R10 compare untouched when disabled", v, 32'd33);
    endtask

    task automatic t_ctl;
        logic [31:0] v;
        wr(12'h240, 32'hFFFF_FFFF);
        rd(12'h240, v); chk("R11 control readback mask", v, 32'h0000_0103);
        wr(12'h240, 32'h0);
        rd(12'h240, v); chk("R11 control cleared", v, 32'h0);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        t_reset;
        t_count;
        t_oneshot;
        t_autoinc;
        t_stop;
        t_ctl;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule